// File: doc/BRIEF.md
# Clock-Synchronous Byte Serial Port

This block moves one byte at a time over a three-wire synchronous link: a serial clock, a transmit data line and a receive data line. Each transfer shifts eight bits out and eight bits in at the same time. A configuration input picks master operation, where the port makes the serial clock by dividing the bus clock, or slave operation, where an external clock is brought into the bus clock domain through a two-stage synchroniser and its edges are found by comparing successive samples.

The clock polarity setting decides where the clock rests and which edge does what. With positive polarity the clock rests high, data changes on the falling edge and is captured on the rising edge. With negative polarity everything is mirrored. Every transfer begins with the edge that leaves the rest level and ends with the edge that returns to it. A second setting picks whether the byte goes out least- or most-significant bit first. Once the eighth bit has been captured, a done flag is set and a one-cycle interrupt pulse is produced. In master mode a DMA request also rises. A write of a new transmit byte clears the flag and arms the next transfer. In master mode that write also starts the clock.

Top module: `sync_serial_port`

## Requirements
- R1: A transfer moves exactly 8 bits each way. The byte written on `tx_data` appears bit by bit on `sdo`, and the 8 bits presented on `sdi` appear on `rx_data` when `done` rises.
- R2: With `cfg_msb_first`=1, bit 7 is sent and received first and bit 0 last. With `cfg_msb_first`=0, bit 0 is first and bit 7 last.
- R3: With `cfg_master`=1, `sclk_oe` is 1. The serial clock changes level every `cfg_half` bus clocks, so the clock divides the bus clock by 2*`cfg_half`. A `cfg_half` of 0 acts as 1. The first clock change comes `cfg_half` bus clocks after the write.
- R4: With `cfg_pol`=1, the clock rests high. `sdo` changes after a falling edge, `sdi` is captured on a rising edge, and in master mode `sclk_o` is high once the byte completes.
- R5: With `cfg_pol`=0, the clock rests low. `sdo` changes after a rising edge, `sdi` is captured on a falling edge, and in master mode `sclk_o` is low once the byte completes.
- R6: After the eighth bit, `sdo` keeps the last data bit sent until the next transfer drives a new bit.
- R7: `done` rises together with a one-cycle `irq` pulse after the eighth capturing edge. A `tx_wr` pulse clears `done` in the next cycle.
- R8: `dma_req` is high while `done` is high in master mode and is always 0 in slave mode.
- R9: With `cfg_master`=0, `sclk_oe` is 0 and the port shifts on edges of `sclk_i`. Clock edges that arrive when no byte has been written since the last completion leave `rx_data`, `sdo`, `done` and `irq` unchanged.
- R10: After reset, `done`, `irq`, `dma_req`, `sdo` and `rx_data` are 0, and `sclk_o` is at the rest level given by `cfg_pol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = generate clock, 0 = follow external clock |
| cfg_pol | input | 1 | 1 = clock rests high, 0 = clock rests low |
| cfg_msb_first | input | 1 | 1 = bit 7 first, 0 = bit 0 first |
| cfg_half | input | DIVW | Master half-period in bus clocks (0 acts as 1) |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Byte to send |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | Transfer complete flag |
| irq | output | 1 | One-cycle completion pulse |
| dma_req | output | 1 | DMA request, master mode only |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Output enable for the serial clock |
| sclk_i | input | 1 | External serial clock in slave mode |
| sdo | output | 1 | Transmit data line |
| sdi | input | 1 | Receive data line |

## Verification
The properties assume that the three configuration inputs and `cfg_half` stay fixed while a byte is in flight, and that `tx_wr` is pulsed only while no transfer is running. In slave mode they also assume that each level of `sclk_i` lasts several bus clocks, so the synchroniser sees every edge and `sdo` settles before the far end captures it. The bench changes settings only between transfers, after `done` has risen. It holds every slave clock level for five bus clocks. A far-end model drives `sdi` right after each leading edge and captures `sdo` on each trailing edge.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DIVW = 8,
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_master,
  input  logic            cfg_pol,
  input  logic            cfg_msb_first,
  input  logic [DIVW-1:0] cfg_half,
  input  logic            tx_wr,
  input  logic [BITS-1:0] tx_data,
  output logic [BITS-1:0] rx_data,
  output logic            done,
  output logic            irq,
  output logic            dma_req,
  output logic            sclk_o,
  output logic            sclk_oe,
  input  logic            sclk_i,
  output logic            sdo,
  input  logic            sdi
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;

  logic            busy, mact, pact;
  logic [1:0]      sync;
  logic [DIVW-1:0] divc;
  logic [CW-1:0]   cnt;
  logic [BITS-1:0] txb;

  wire [DIVW-1:0] half_eff = (cfg_half == '0) ? DIVW'(1) : cfg_half;
  wire            tick     = busy & cfg_master & (divc == half_eff - DIVW'(1));
  wire            ext_act  = sync[1] ^ cfg_pol;
  wire            lead     = cfg_master ? (tick & ~mact) : (busy & ext_act & ~pact);
  wire            trail    = cfg_master ? (tick & mact)  : (busy & ~ext_act & pact);
  wire [CW-1:0]   idx      = cfg_msb_first ? (CW'(BITS-1) - cnt) : cnt;
  wire            last     = (cnt == CW'(BITS-1));

  assign sclk_o  = mact ^ cfg_pol;
  assign sclk_oe = cfg_master;
  assign dma_req = done & cfg_master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mact    <= 1'b0;
      pact    <= 1'b0;
      sync    <= '0;
      divc    <= '0;
      cnt     <= '0;
      txb     <= '0;
      rx_data <= '0;
      done    <= 1'b0;
      irq     <= 1'b0;
      sdo     <= 1'b0;
    end else begin
      sync <= {sync[0], sclk_i};
      pact <= ext_act;
      irq  <= 1'b0;
      if (tx_wr) begin
        txb  <= tx_data;
        busy <= 1'b1;
        done <= 1'b0;
        cnt  <= '0;
        divc <= '0;
        mact <= 1'b0;
      end else begin
        if (tick) begin
          divc <= '0;
          mact <= ~mact;
        end else if (busy && cfg_master) begin
          divc <= divc + DIVW'(1);
        end
        if (lead) sdo <= txb[idx];
        if (trail) begin
          rx_data[idx] <= sdi;
          cnt          <= cnt + CW'(1);
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
            irq  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module sync_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_pol,
  input logic tx_wr,
  input logic done,
  input logic irq,
  input logic dma_req,
  input logic sclk_o,
  input logic sdo
);
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && !$past(irq)));
  assert_wr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !done);
  assert_rest_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_master && cfg_pol) |-> sclk_o);
  assert_rest_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_master && !cfg_pol) |-> !sclk_o);
  assert_hold_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(sdo));
  assert_no_dma_slave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master) |-> !dma_req);
endmodule

bind sync_serial_port sync_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_pol(cfg_pol),
  .tx_wr(tx_wr), .done(done), .irq(irq), .dma_req(dma_req),
  .sclk_o(sclk_o), .sdo(sdo)
);

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_master = 1'b1, cfg_pol = 1'b1, cfg_msb_first = 1'b0;
  logic [7:0] cfg_half = 8'd1;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic       done, irq, dma_req, sclk_o, sclk_oe, sdo;
  logic       sclk_i = 1'b1;
  logic       sdi = 1'b0;

  always #2 clk = ~clk;

  sync_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_pol(cfg_pol),
    .cfg_msb_first(cfg_msb_first), .cfg_half(cfg_half), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_data(rx_data), .done(done), .irq(irq),
    .dma_req(dma_req), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
    .sdo(sdo), .sdi(sdi)
  );

  typedef struct { logic [7:0] tx; logic [7:0] rx; logic lastbit; logic m; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  int irq_n = 0;
  logic [7:0] p_rx_byte = 8'h00;
  int half_exp = 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // far-end partner and scoreboard monitor
  logic [7:0] p_cap = 8'h00;
  int  p_k = 0, p_edges = 0, since = 0, half_err = 0;
  logic line_prev = 1'b1, done_prev = 1'b0;
  always @(negedge clk) begin
    logic line;
    int   pos;
    exp_t e;
    line = cfg_master ? sclk_o : sclk_i;
    since++;
    if (irq) irq_n++;
    if (tx_wr) begin
      p_k = 0; p_edges = 0; half_err = 0; p_cap = 8'h00; since = 0;
    end else if (rst_n && line != line_prev) begin
      if (p_edges > 0 && since != half_exp) half_err++;
      since = 0;
      p_edges++;
      if (p_k < 8) begin
        pos = cfg_msb_first ? 7 - p_k : p_k;
        if (line != cfg_pol) sdi <= p_rx_byte[pos];
        else begin
          p_cap[pos] = sdo;
          p_k++;
        end
      end
    end
    line_prev = line;
    if (rst_n && done && !done_prev) begin
      if (q.size() == 0) check(0, "R7", "done without pending transfer", 1, 0);
      else begin
        e = q.pop_front();
        check(rx_data == e.rx, "R1", "received byte", rx_data, e.rx);
        check(p_cap == e.tx, "R2", "byte seen on sdo in chosen order", p_cap, e.tx);
        check(sdo == e.lastbit, "R6", "sdo holds last bit", sdo, e.lastbit);
        if (e.m) begin
          check(sclk_o == cfg_pol, cfg_pol ? "R4" : "R5", "clock rest level", sclk_o, cfg_pol);
          check(half_err == 0, "R3", "half-period mismatches", half_err, 0);
          check(sclk_oe == 1'b1, "R3", "clock output enabled", sclk_oe, 1);
          check(dma_req == 1'b1, "R8", "dma request in master", dma_req, 1);
        end else begin
          check(dma_req == 1'b0, "R8", "no dma request in slave", dma_req, 0);
          check(sclk_oe == 1'b0, "R9", "clock output disabled", sclk_oe, 0);
        end
      end
    end
    done_prev = done;
  end

  int irq_exp = 0;

  task automatic xfer(input bit m, input bit pol, input bit msb, input int half,
                      input logic [7:0] txb, input logic [7:0] rxb);
    exp_t e;
    int w;
    @(negedge clk);
    cfg_master = m; cfg_pol = pol; cfg_msb_first = msb; cfg_half = 8'(half);
    sclk_i = pol;
    p_rx_byte = rxb;
    half_exp = (half == 0) ? 1 : half;
    e.tx = txb; e.rx = rxb; e.lastbit = msb ? txb[0] : txb[7]; e.m = m;
    q.push_back(e);
    repeat (4) @(negedge clk);
    tx_wr = 1'b1; tx_data = txb;
    @(negedge clk);
    tx_wr = 1'b0;
    check(done == 1'b0, "R7", "write clears done", done, 0);
    check(dma_req == 1'b0, "R8", "write clears dma request", dma_req, 0);
    if (!m) begin
      for (int b = 0; b < 8; b++) begin
        repeat (5) @(posedge clk); #1 sclk_i = ~pol;
        repeat (5) @(posedge clk); #1 sclk_i = pol;
      end
    end
    w = 0;
    while (!done && w < 4000) begin @(negedge clk); w++; end
    check(done == 1'b1, "R7", "done reached", done, 1);
    repeat (3) @(negedge clk);
    irq_exp++;
    check(irq_n == irq_exp, "R7", "irq pulse count", irq_n, irq_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rx_keep;
    logic       sdo_keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R10", "done after reset", done, 0);
    check(irq == 1'b0, "R10", "irq after reset", irq, 0);
    check(dma_req == 1'b0, "R10", "dma after reset", dma_req, 0);
    check(sdo == 1'b0, "R10", "sdo after reset", sdo, 0);
    check(rx_data == 8'h00, "R10", "rx_data after reset", rx_data, 0);
    check(sclk_o == 1'b1, "R10", "clock rest level after reset", sclk_o, 1);

    xfer(1, 1, 0, 1, 8'hA5, 8'h3C);
    xfer(1, 1, 1, 3, 8'h81, 8'h7E);
    xfer(1, 0, 1, 2, 8'h4B, 8'hD2);
    xfer(1, 0, 0, 0, 8'h01, 8'h80);
    xfer(0, 1, 1, 1, 8'hC3, 8'h96);
    xfer(0, 0, 0, 1, 8'h5A, 8'h0F);

    // R9: edges with no byte armed are ignored
    rx_keep = rx_data; sdo_keep = sdo;
    for (int b = 0; b < 8; b++) begin
      repeat (5) @(posedge clk); #1 sclk_i = 1'b1;
      repeat (5) @(posedge clk); #1 sclk_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    check(rx_data == rx_keep, "R9", "rx_data unchanged by idle edges", rx_data, rx_keep);
    check(sdo == sdo_keep, "R9", "sdo unchanged by idle edges", sdo, sdo_keep);
    check(done == 1'b1, "R9", "done kept through idle edges", done, 1);
    check(irq_n == irq_exp, "R9", "no irq from idle edges", irq_n, irq_exp);
    check(q.size() == 0, "R1", "all transfers completed", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule